// File: doc/BRIEF.md
# Floating-Point Status Field Immediate Writer

This block holds a 32-bit floating-point status and control register. It executes one instruction: loading a 4-bit constant into a single nibble of that register. Each cycle, a 32-bit instruction word can arrive with a valid strobe. The block decodes the word and picks one of eight nibbles with a 3-bit index counted from the most significant end. It writes the constant carried in the word into that nibble and leaves every other bit as it was.

When the word's record flag is set, the block also copies the top nibble of the updated register into condition-register field 1. This nibble holds the four summary flags. The copy comes out with a one-cycle write-enable pulse.

A build-time option selects the newer-architecture behaviour. With it on, the two summary bits in the top nibble (the enabled-exception summary and the invalid-operation summary) cannot be changed by this instruction. The block also drives the current rounding mode, taken from the lowest two bits of the register, as a separate output.

Top module: `fsfi_unit`

## Requirements
- R1: While reset is active, and after it is released, the status register reads zero, the CR1 value reads zero and the CR1 write-enable is low.
- R2: A word is executed only when valid is high, raw bits [31:26] equal 63 and raw bits [10:1] equal 134. Any other word, or any word without valid, leaves the status register and the CR1 value unchanged and keeps the CR1 write-enable low.
- R3: The field index is raw bits [25:23] and the constant is raw bits [15:12]. Field n occupies register bits [31-4n : 28-4n], so field 0 is the most significant nibble.
- R4: An executed write changes no register bit outside the selected nibble.
- R5: When raw bit 0 (the record flag) is 1, the CR1 write-enable is high for the one cycle after the instruction, and the CR1 value equals register bits [31:28] after the write. When the flag is 0, the enable stays low and the CR1 value holds.
- R6: The rounding-mode output equals register bits [1:0], which are the low two bits of field 7. The codes are 0 for nearest, 1 for toward zero, 2 for toward plus infinity and 3 for toward minus infinity.
- R7: With PROTECT_SUMMARY set, register bits 30 and 29 keep their previous values on every write, including writes to field 0. The CR1 copy shows these kept bits, not the constant's bits.
- R8: With PROTECT_SUMMARY clear, a write to field 0 stores all four constant bits, bits 30 and 29 included.
- R9: Results appear on the clock edge after the valid instruction, and one instruction can be accepted every cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Raw instruction word |
| fpscr | output | 32 | Current status and control register |
| roundMode | output | 2 | Current rounding mode |
| cr1Val | output | 4 | Summary nibble for condition-register field 1 |
| cr1We | output | 1 | One-cycle write-enable for cr1Val |

## Verification
The field write and the CR1 mirror land on the same clock edge. The mirror must carry the nibble as it stands after the write, not the value from the cycle before. The bench provokes this by sending record-form writes to field 0, the field that feeds the mirror, right after other writes with no idle cycle in between. It runs one copy of the block with protection on and one with it off. A scoreboard model predicts the register and the CR1 nibble for both copies, and the bench checks that the protected copy mirrors the kept summary bits rather than the constant's bits.

// File: rtl/fsfi_pkg.sv
package fsfi_pkg;
  localparam int WORD_W  = 32;
  localparam int NIB_W   = 4;
  localparam int FIELDS  = WORD_W / NIB_W;
  localparam int IDX_W   = $clog2(FIELDS);
  localparam int PRI_W   = 6;
  localparam int EXT_W   = 10;
  localparam int PRI_OP  = 63;
  localparam int EXT_OP  = 134;
  localparam int PRI_LO  = WORD_W - PRI_W;
  localparam int IDX_LO  = PRI_LO - IDX_W;
  localparam int IMM_LO  = 12;
  localparam int EXT_LO  = 1;
  localparam int REC_BIT = 0;
  localparam int FEX_BIT = WORD_W - 2;
  localparam int VX_BIT  = WORD_W - 3;

  typedef struct packed {
    logic             wr;
    logic             rec;
    logic [IDX_W-1:0] field;
    logic [NIB_W-1:0] imm;
  } fsfi_ctl_t;
endpackage

// File: rtl/fsfi_ctrl.sv
module fsfi_ctrl
  import fsfi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output fsfi_ctl_t         ctl
);
  logic priHit;
  logic extHit;

  always_comb begin
    priHit    = instrWord[WORD_W-1 -: PRI_W] == PRI_W'(PRI_OP);
    extHit    = instrWord[EXT_LO +: EXT_W] == EXT_W'(EXT_OP);
    ctl.wr    = instrValid && priHit && extHit;
    ctl.rec   = instrWord[REC_BIT];
    ctl.field = instrWord[IDX_LO +: IDX_W];
    ctl.imm   = instrWord[IMM_LO +: NIB_W];
  end

  AST_NO_WRITE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !ctl.wr); // R2
endmodule

// File: rtl/fsfi_datapath.sv
module fsfi_datapath
  import fsfi_pkg::*;
#(
  parameter bit PROTECT_SUMMARY = 1'b0
)(
  input  logic              clk,
  input  logic              rstN,
  input  fsfi_ctl_t         ctl,
  output logic [WORD_W-1:0] fpscr,
  output logic [NIB_W-1:0]  cr1Val,
  output logic              cr1We
);
  logic [WORD_W-1:0] statReg;
  logic [WORD_W-1:0] nextRaw;
  logic [WORD_W-1:0] nextStat;
  logic [WORD_W-1:0] wrMask;
  logic [FIELDS-1:0] fieldHit;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    localparam int HI = WORD_W - 1 - g * NIB_W;
    assign fieldHit[g]          = ctl.wr && (ctl.field == IDX_W'(g));
    assign wrMask[HI -: NIB_W]  = {NIB_W{fieldHit[g]}};
    assign nextRaw[HI -: NIB_W] = fieldHit[g] ? ctl.imm : statReg[HI -: NIB_W];
  end

  if (PROTECT_SUMMARY) begin : g_protect
    always_comb begin
      nextStat          = nextRaw;
      nextStat[FEX_BIT] = statReg[FEX_BIT];
      nextStat[VX_BIT]  = statReg[VX_BIT];
    end

    AST_SUMMARY_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      ctl.wr |=> (statReg[FEX_BIT] == $past(statReg[FEX_BIT])) &&
                 (statReg[VX_BIT] == $past(statReg[VX_BIT]))); // R7
  end else begin : g_open
    assign nextStat = nextRaw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      cr1Val  <= '0;
      cr1We   <= 1'b0;
    end else begin
      cr1We <= ctl.wr && ctl.rec;
      if (ctl.wr) statReg <= nextStat;
      if (ctl.wr && ctl.rec) cr1Val <= nextStat[WORD_W-1 -: NIB_W];
    end
  end

  assign fpscr = statReg;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wr |=> $stable(statReg) && !cr1We); // R2
  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |=> ((statReg ^ $past(statReg)) & ~$past(wrMask)) == '0); // R4
  AST_CR1_MIRRORS_TOP: assert property (@(posedge clk) disable iff (!rstN)
    cr1We |-> cr1Val == statReg[WORD_W-1 -: NIB_W]); // R5
  AST_CR1_ONLY_ON_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wr && ctl.rec) |=> !cr1We && $stable(cr1Val)); // R5
  AST_ONE_FIELD_AT_MOST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fieldHit)); // R3
endmodule

// File: rtl/fsfi_unit.sv
module fsfi_unit
  import fsfi_pkg::*;
#(
  parameter bit PROTECT_SUMMARY = 1'b0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  output logic [31:0] fpscr,
  output logic [1:0]  roundMode,
  output logic [3:0]  cr1Val,
  output logic        cr1We
);
  fsfi_ctl_t ctl;

  fsfi_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctl        (ctl)
  );

  fsfi_datapath #(.PROTECT_SUMMARY(PROTECT_SUMMARY)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .fpscr  (fpscr),
    .cr1Val (cr1Val),
    .cr1We  (cr1We)
  );

  assign roundMode = fpscr[1:0];
endmodule

// File: tb/fsfi_unit_tb.sv
module fsfi_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] expA;
    logic [31:0] expB;
    logic        expWe;
    logic [3:0]  expCrA;
    logic [3:0]  expCrB;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] fpscrA, fpscrB;
  logic [1:0]  rmA, rmB;
  logic [3:0]  crA, crB;
  logic        weA, weB;

  int checks = 0;
  int fails = 0;
  item_t q[$];
  logic [31:0] mA = '0, mB = '0;
  logic [3:0]  mCrA = '0, mCrB = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsfi_unit #(.PROTECT_SUMMARY(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .fpscr(fpscrA), .roundMode(rmA), .cr1Val(crA), .cr1We(weA));

  fsfi_unit #(.PROTECT_SUMMARY(1'b1)) dut_p_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .fpscr(fpscrB), .roundMode(rmB), .cr1Val(crB), .cr1We(weB));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int fld, input int imm, input bit rc);
    logic [31:0] w = '0;
    w[31:26] = 6'd63;
    w[25:23] = 3'(fld);
    w[15:12] = 4'(imm);
    w[10:1]  = 10'd134;
    w[0]     = rc;
    return w;
  endfunction

  task automatic send(input bit v, input logic [31:0] w, input string tag);
    item_t it;
    bit hit;
    int sh;
    @(negedge clk);
    instrValid = v;
    instrWord  = w;
    hit = v && (w[31:26] == 6'd63) && (w[10:1] == 10'd134);
    if (hit) begin
      sh = 28 - 4 * int'(w[25:23]);
      mA = (mA & ~(32'hF << sh)) | (32'(w[15:12]) << sh);
      mB = ((mB & ~(32'hF << sh)) | (32'(w[15:12]) << sh) & ~32'h6000_0000) |
           (mB & 32'h6000_0000);
      if (w[0]) begin
        mCrA = mA[31:28];
        mCrB = mB[31:28];
      end
    end
    it.expA = mA; it.expB = mB; it.expWe = hit && w[0];
    it.expCrA = mCrA; it.expCrB = mCrB; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(fpscrA == it.expA, it.tag, "fpscr open", fpscrA, it.expA);
      chk(fpscrB == it.expB, it.tag, "fpscr protected", fpscrB, it.expB);
      chk(weA == it.expWe && weB == it.expWe, it.tag, "cr1We", {30'd0, weB, weA},
          {30'd0, it.expWe, it.expWe});
      chk(crA == it.expCrA, it.tag, "cr1Val open", 32'(crA), 32'(it.expCrA));
      chk(crB == it.expCrB, it.tag, "cr1Val protected", 32'(crB), 32'(it.expCrB));
      chk(rmA == it.expA[1:0], "R6", "roundMode", 32'(rmA), 32'(it.expA[1:0]));
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #1;
    chk(fpscrA == 0 && fpscrB == 0, "R1", "fpscr in reset", fpscrA | fpscrB, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(fpscrA == 0 && crA == 0 && !weA && !weB, "R1", "state after reset",
        {fpscrA[27:0], crA} | {31'd0, weA | weB}, 0);

    send(1, mk(7, 2, 0), "R6 plus-inf");
    send(1, mk(7, 1, 0), "R6 toward-zero");
    send(1, mk(7, 3, 0), "R6 minus-inf");
    send(1, mk(7, 0, 0), "R6 nearest");
    for (int f = 0; f < 8; f++) send(1, mk(f, f + 8, 0), "R3 R9 field sweep");
    send(1, mk(3, 0, 0), "R4 clear field 3");
    send(1, mk(6, 5, 1), "R5 record other field");
    send(0, mk(2, 7, 1), "R2 no valid");
    w = mk(2, 7, 1); w[31:26] = 6'd62;
    send(1, w, "R2 bad primary");
    w = mk(2, 7, 1); w[10:1] = 10'd135;
    send(1, w, "R2 bad extended");
    send(1, mk(0, 15, 1), "R7 R8 field0 record");
    send(1, mk(5, 6, 0), "R5 no record holds");
    send(1, mk(0, 0, 1), "R8 field0 clear record");
    send(1, mk(0, 9, 1), "R7 R9 back-to-back record");
    send(1, mk(7, 3, 1), "R5 R6 record field7");
    send(0, 32'h0, "R2 idle");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule